// File: doc/BRIEF.md
# Register-Resident Ethernet Descriptor Ring

This block keeps the DMA descriptor state for a small Ethernet MAC whose descriptors are registers rather than memory. It holds a transmit ring and a receive ring of four slots each. Every slot has a buffer word, which packs a 16-byte-aligned buffer address with four control bits, and a status word that the MAC engine fills when a frame finishes. Transmit slots also carry a frame length. Software programs the slots through a simple register port and hands each slot to hardware by setting its enable bit.

The receive and transmit engines are abstracted to a ready indication, the current slot's buffer address (and, for transmit, its length), and a one-cycle completion strobe carrying a status word. On an accepted completion the ring marks the slot done, takes it back from hardware and steps to the next slot in circular order. A completion that finds its slot not handed over stalls the ring, and on the receive side raises a missed-frame pulse. A level interrupt stays high while any slot is done. Writing zero to the enable register strips every slot's control bits and stops both engines.

Register map (byte addresses): transmit slot n at 0x000 + 16n, receive slot n at 0x100 + 16n; within a slot, +0x0 status (read only), +0x4 length (transmit only), +0x8 buffer word. Enable register at 0x200, bit 0. Other addresses read 0 and ignore writes.

Top module: `eth_desc_ring_top`

## Requirements
- R1: After reset every slot word, the enable register, `irq`, `tx_ready`, `rx_ready` and `rx_missed` are 0 and both ring indices are 0.
- R2: A write to a buffer word stores bits [31:4] as the address and bit 0 as the enable bit; bit 1 (done) can only be cleared by software, and is also cleared whenever the write sets bit 0, so a slot is never both enabled and done.
- R3: Bits [3:2] of slot 0's buffer word read back that ring's current hardware index; in slots 1 to 3 those bits read 0 and are never written by software.
- R4: While the enable register bit 0 is 1, a completion strobe whose current slot is enabled sets that slot's done bit (bit 1), clears its enable bit in the same cycle, stores the status word and steps the index, wrapping from 3 to 0.
- R5: A completion strobe whose current slot is not enabled changes no slot and leaves the index in place; on the receive side `rx_missed` is high for exactly the one cycle after that strobe.
- R6: A stored receive status keeps bits [30:0] as delivered ([13:0] is the frame length including the 4-byte FCS, [24:16] are error flags) and sets bit 31 to the OR of bits [24:16].
- R7: `irq` is high exactly while any done bit in either ring is set, and falls once software clears the last one.
- R8: Writing the enable register with bit 0 = 0 clears the enable and done bits of all eight slots while addresses, lengths and indices are kept; while the enable register is 0, completion strobes are ignored.
- R9: `tx_ready`, `tx_buf_addr`, `tx_len`, `rx_ready` and `rx_buf_addr` show the enable bit, the address (low 4 bits zero) and the length of each ring's current slot.
- R10: A transmit length write stores the low LEN_W (14) bits; the receive length word reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 10 | Register byte address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| tx_ready | output | 1 | Current transmit slot is handed to hardware |
| tx_buf_addr | output | 32 | Buffer address of the current transmit slot |
| tx_len | output | 14 | Frame length of the current transmit slot |
| tx_done | input | 1 | Transmit frame-complete strobe |
| tx_status | input | 32 | Transmit completion status |
| rx_ready | output | 1 | Current receive slot is handed to hardware |
| rx_buf_addr | output | 32 | Buffer address of the current receive slot |
| rx_done | input | 1 | Receive frame-complete strobe |
| rx_status | input | 32 | Receive completion status |
| rx_missed | output | 1 | One-cycle pulse after a receive completion found no ready slot |
| irq | output | 1 | Level interrupt, high while any slot is done |

## Verification
The assertions watch, every cycle, that no slot is both enabled and done, that an accepted completion moves the index by one, that a stalled completion holds the index and on the receive side raises the missed pulse, that a clear leaves no done or ready slot, and that the interrupt only rises after a completion strobe. Only the scenarios show the values: the address and index packing of the buffer word, the folded receive error bit, wrap-around after four frames, the length masking, and that a clear keeps addresses and indices while a disabled MAC ignores strobes.

// File: rtl/eth_desc_pkg.sv
package eth_desc_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned DONE_BIT = 1;
  localparam int unsigned FLAG_LO  = 16;
  localparam int unsigned FLAG_HI  = 24;
  localparam int unsigned ERR_BIT  = 31;

  // word select inside one slot (byte offset bits [3:2])
  localparam logic [1:0] W_STAT = 2'd0;
  localparam logic [1:0] W_LEN  = 2'd1;
  localparam logic [1:0] W_BUF  = 2'd2;

  // receive status as stored: summary error bit folded into bit 31
  function automatic logic [WORD_W-1:0] fold_rx_status(input logic [WORD_W-1:0] s);
    logic [WORD_W-1:0] r;
    r = s;
    r[ERR_BIT] = |s[FLAG_HI:FLAG_LO];
    return r;
  endfunction

  // done survives a software write only if kept at 1 and the slot stays with software
  function automatic logic done_after_write(input logic old_done, input logic [WORD_W-1:0] wd);
    return old_done & wd[DONE_BIT] & ~wd[EN_BIT];
  endfunction

  // circular successor of a slot index
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
    return (idx + 1 == n) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/eth_desc_decode.sv
module eth_desc_decode #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned NSLOT  = 4,
  localparam int unsigned IDX_W = $clog2(NSLOT)
) (
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  output logic              tx_hit,
  output logic              rx_hit,
  output logic              en_hit,
  output logic              tx_wr,
  output logic              rx_wr,
  output logic              en_wr,
  output logic [IDX_W-1:0]  slot,
  output logic [1:0]        word
);
  localparam int unsigned SLOT_BYTES = 16;
  localparam int unsigned SPAN       = NSLOT * SLOT_BYTES;
  localparam int unsigned RX_BASE    = 'h100;
  localparam int unsigned EN_ADDR    = 'h200;

  logic unused_low;
  assign unused_low = ^reg_addr[1:0];

  assign tx_hit = reg_addr < ADDR_W'(SPAN);
  assign rx_hit = (reg_addr >= ADDR_W'(RX_BASE)) && (reg_addr < ADDR_W'(RX_BASE + SPAN));
  assign en_hit = reg_addr == ADDR_W'(EN_ADDR);

  assign slot = reg_addr[4 +: IDX_W];
  assign word = reg_addr[3:2];

  assign tx_wr = reg_we && tx_hit;
  assign rx_wr = reg_we && rx_hit;
  assign en_wr = reg_we && en_hit;
endmodule

// File: rtl/eth_desc_ring.sv
module eth_desc_ring
  import eth_desc_pkg::*;
#(
  parameter int unsigned NSLOT = 4,
  parameter int unsigned LEN_W = 14,
  parameter bit          IS_RX = 1'b0,
  localparam int unsigned IDX_W = $clog2(NSLOT),
  localparam int unsigned ADR_W = WORD_W - 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  acc_slot,
  input  logic [1:0]        acc_word,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic              clr_ctrl,
  input  logic              mac_en,
  input  logic              done_stb,
  input  logic [WORD_W-1:0] done_status,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              cur_ready,
  output logic [WORD_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  cur_len,
  output logic              any_done,
  output logic              stall_ev
);
  logic [IDX_W-1:0]  idx_q;
  logic [NSLOT-1:0]  en_q;
  logic [NSLOT-1:0]  done_q;
  logic [ADR_W-1:0]  addr_q [NSLOT];
  logic [LEN_W-1:0]  len_q  [NSLOT];
  logic [WORD_W-1:0] stat_q [NSLOT];

  // named events for assertions
  logic live;
  logic accept;
  assign live      = done_stb && mac_en && !clr_ctrl;
  assign cur_ready = en_q[idx_q];
  assign accept    = live && cur_ready;
  assign stall_ev  = live && !cur_ready;

  logic unused_wd;
  assign unused_wd = ^wr_data[3:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (accept) begin
      idx_q <= IDX_W'(ring_next(int'(idx_q), NSLOT));
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic              en_s, done_s;
    logic [ADR_W-1:0]  addr_s;
    logic [LEN_W-1:0]  len_s;
    logic [WORD_W-1:0] stat_s;
    logic hit_wr, hit_buf, hit_done;

    assign hit_wr   = wr_en && (acc_slot == IDX_W'(g));
    assign hit_buf  = hit_wr && (acc_word == W_BUF);
    assign hit_done = accept && (idx_q == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_s   <= 1'b0;
        done_s <= 1'b0;
        addr_s <= '0;
        len_s  <= '0;
        stat_s <= '0;
      end else begin
        if (hit_buf) addr_s <= wr_data[WORD_W-1:4];
        if (hit_wr && acc_word == W_LEN && !IS_RX) len_s <= wr_data[LEN_W-1:0];
        if (hit_done) stat_s <= IS_RX ? fold_rx_status(done_status) : done_status;
        if (clr_ctrl) begin
          en_s   <= 1'b0;
          done_s <= 1'b0;
        end else if (hit_done) begin
          en_s   <= 1'b0;
          done_s <= 1'b1;
        end else if (hit_buf) begin
          en_s   <= wr_data[EN_BIT];
          done_s <= done_after_write(done_s, wr_data);
        end
      end
    end

    assign en_q[g]   = en_s;
    assign done_q[g] = done_s;
    assign addr_q[g] = addr_s;
    assign len_q[g]  = len_s;
    assign stat_q[g] = stat_s;

    // R2: a slot is never enabled and done at once
    p_en_done_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(en_s && done_s));
  end

  logic [1:0] idx_field;
  assign idx_field = 2'(idx_q);

  always_comb begin
    rd_data = '0;
    case (acc_word)
      W_STAT: rd_data = stat_q[acc_slot];
      W_LEN:  rd_data = IS_RX ? '0 : WORD_W'(len_q[acc_slot]);
      W_BUF:  rd_data = {addr_q[acc_slot],
                         (acc_slot == '0) ? idx_field : 2'b00,
                         done_q[acc_slot], en_q[acc_slot]};
      default: rd_data = '0;
    endcase
  end

  assign cur_idx  = idx_q;
  assign cur_addr = {addr_q[idx_q], 4'b0000};
  assign cur_len  = IS_RX ? '0 : len_q[idx_q];
  assign any_done = |done_q;

  // R4: an accepted completion moves the index by exactly one slot
  p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> idx_q == IDX_W'($past(idx_q) + 1'b1));

  // R8: after a clear nothing is done and nothing is handed to hardware
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ctrl |=> (!any_done && !cur_ready));
endmodule

// File: rtl/eth_desc_ring_top.sv
module eth_desc_ring_top
  import eth_desc_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned NSLOT  = 4,
  parameter int unsigned LEN_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              tx_ready,
  output logic [31:0]       tx_buf_addr,
  output logic [LEN_W-1:0]  tx_len,
  input  logic              tx_done,
  input  logic [31:0]       tx_status,
  output logic              rx_ready,
  output logic [31:0]       rx_buf_addr,
  input  logic              rx_done,
  input  logic [31:0]       rx_status,
  output logic              rx_missed,
  output logic              irq
);
  localparam int unsigned IDX_W = $clog2(NSLOT);

  logic tx_hit, rx_hit, en_hit, tx_wr, rx_wr, en_wr;
  logic [IDX_W-1:0] slot;
  logic [1:0]       word;

  eth_desc_decode #(.ADDR_W(ADDR_W), .NSLOT(NSLOT)) u_dec (
    .reg_addr(reg_addr), .reg_we(reg_we),
    .tx_hit(tx_hit), .rx_hit(rx_hit), .en_hit(en_hit),
    .tx_wr(tx_wr), .rx_wr(rx_wr), .en_wr(en_wr),
    .slot(slot), .word(word)
  );

  logic mac_en_q;
  logic clr_ctrl;
  assign clr_ctrl = en_wr && !reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mac_en_q <= 1'b0;
    else if (en_wr) mac_en_q <= reg_wdata[0];
  end

  logic [31:0]      tx_rd, rx_rd;
  logic [IDX_W-1:0] tx_idx, rx_idx;
  logic             tx_any, rx_any, tx_stall, rx_stall;
  logic [LEN_W-1:0] rx_len_unused;

  eth_desc_ring #(.NSLOT(NSLOT), .LEN_W(LEN_W), .IS_RX(1'b0)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tx_wr), .acc_slot(slot), .acc_word(word), .wr_data(reg_wdata), .rd_data(tx_rd),
    .clr_ctrl(clr_ctrl), .mac_en(mac_en_q),
    .done_stb(tx_done), .done_status(tx_status),
    .cur_idx(tx_idx), .cur_ready(tx_ready), .cur_addr(tx_buf_addr), .cur_len(tx_len),
    .any_done(tx_any), .stall_ev(tx_stall)
  );

  eth_desc_ring #(.NSLOT(NSLOT), .LEN_W(LEN_W), .IS_RX(1'b1)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .wr_en(rx_wr), .acc_slot(slot), .acc_word(word), .wr_data(reg_wdata), .rd_data(rx_rd),
    .clr_ctrl(clr_ctrl), .mac_en(mac_en_q),
    .done_stb(rx_done), .done_status(rx_status),
    .cur_idx(rx_idx), .cur_ready(rx_ready), .cur_addr(rx_buf_addr), .cur_len(rx_len_unused),
    .any_done(rx_any), .stall_ev(rx_stall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_missed <= 1'b0;
    else rx_missed <= rx_stall;
  end

  assign irq = tx_any || rx_any;

  always_comb begin
    if (tx_hit)      reg_rdata = tx_rd;
    else if (rx_hit) reg_rdata = rx_rd;
    else if (en_hit) reg_rdata = {31'b0, mac_en_q};
    else             reg_rdata = '0;
  end

  // R5: a stalled receive completion is reported on the next cycle
  p_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stall |=> rx_missed);

  // R5: a stalled transmit completion keeps the ring where it is
  p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stall |=> $stable(tx_idx));

  // R7: the interrupt only rises after a completion strobe
  p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tx_done || rx_done));

  // R8: with the MAC disabled a receive strobe neither moves nor misses
  p_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mac_en_q && rx_done) |=> ($stable(rx_idx) && !rx_missed));

  logic unused_rx_len;
  assign unused_rx_len = ^rx_len_unused;
endmodule

// File: tb/eth_desc_ring_tb_top.sv
module eth_desc_ring_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_ready, rx_ready, rx_missed, irq;
  logic [31:0] tx_buf_addr, rx_buf_addr;
  logic [13:0] tx_len;
  logic        tx_done = 1'b0, rx_done = 1'b0;
  logic [31:0] tx_status = '0, rx_status = '0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  eth_desc_ring_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_ready(tx_ready), .tx_buf_addr(tx_buf_addr), .tx_len(tx_len),
    .tx_done(tx_done), .tx_status(tx_status),
    .rx_ready(rx_ready), .rx_buf_addr(rx_buf_addr),
    .rx_done(rx_done), .rx_status(rx_status),
    .rx_missed(rx_missed), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic tx_pulse(input logic [31:0] s);
    @(negedge clk);
    tx_done = 1'b1; tx_status = s;
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  task automatic rx_pulse(input logic [31:0] s);
    @(negedge clk);
    rx_done = 1'b1; rx_status = s;
    @(negedge clk);
    rx_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(10'h008, d); chk("R1 tx slot0 buf", d, 32'h0);
    rd(10'h108, d); chk("R1 rx slot0 buf", d, 32'h0);
    rd(10'h200, d); chk("R1 enable reg", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 ready/missed", {29'b0, tx_ready, rx_ready, rx_missed}, 32'h0);
  endtask

  task automatic t_write();
    logic [31:0] d;
    wr(10'h018, 32'hABCD_123F);
    rd(10'h018, d); chk("R2 R3 slot1 buf write", d, 32'hABCD_1231);
    wr(10'h018, 32'hABCD_1232);
    rd(10'h018, d); chk("R2 sw cannot set done", d, 32'hABCD_1230);
    chk("R7 no irq from sw", {31'b0, irq}, 32'h0);
    wr(10'h014, 32'h0000_FFFF);
    rd(10'h014, d); chk("R10 tx len masked", d, 32'h0000_3FFF);
    wr(10'h114, 32'h0000_FFFF);
    rd(10'h114, d); chk("R10 rx len reads 0", d, 32'h0);
    rd(10'h300, d); chk("R1 unmapped reads 0", d, 32'h0);
  endtask

  task automatic t_tx();
    logic [31:0] d;
    wr(10'h200, 32'h1);
    for (int i = 0; i < 4; i++) begin
      wr(10'(i * 16 + 4), 32'(60 + i));
      wr(10'(i * 16 + 8), 32'h1000 + 32'(i) * 32'h100 + 32'h1);
    end
    rd(10'h008, d); chk("R3 idx 0 in slot0", d, 32'h0000_1001);
    chk("R9 tx ready", {31'b0, tx_ready}, 32'h1);
    chk("R9 tx addr", tx_buf_addr, 32'h1000);
    chk("R9 tx len", {18'b0, tx_len}, 32'd60);
    tx_pulse(32'h5);
    rd(10'h008, d); chk("R4 done, en off, idx 1", d, 32'h0000_1006);
    rd(10'h000, d); chk("R4 tx status stored", d, 32'h5);
    chk("R9 next tx addr", tx_buf_addr, 32'h1100);
    chk("R9 next tx len", {18'b0, tx_len}, 32'd61);
    chk("R7 irq on done", {31'b0, irq}, 32'h1);
    tx_pulse(32'h6); tx_pulse(32'h7); tx_pulse(32'h8);
    rd(10'h008, d); chk("R4 wrap to idx 0", d, 32'h0000_1002);
    rd(10'h030, d); chk("R4 slot3 status", d, 32'h8);
    chk("R5 tx not ready after wrap", {31'b0, tx_ready}, 32'h0);
    tx_pulse(32'hEE);
    rd(10'h008, d); chk("R5 stalled tx keeps idx", d, 32'h0000_1002);
    rd(10'h000, d); chk("R5 stalled tx keeps status", d, 32'h5);
    for (int i = 0; i < 3; i++) wr(10'(i * 16 + 8), 32'h1000 + 32'(i) * 32'h100);
    chk("R7 irq held by last done", {31'b0, irq}, 32'h1);
    wr(10'h038, 32'h1300);
    chk("R7 irq drops after ack", {31'b0, irq}, 32'h0);
    rd(10'h008, d); chk("R2 ack clears done", d, 32'h0000_1000);
  endtask

  task automatic t_rx();
    logic [31:0] d;
    wr(10'h108, 32'h2001);
    wr(10'h118, 32'h2101);
    chk("R9 rx ready", {31'b0, rx_ready}, 32'h1);
    chk("R9 rx addr", rx_buf_addr, 32'h2000);
    rx_pulse(32'h0010_0040);
    rd(10'h100, d); chk("R6 error bit folded", d, 32'h8010_0040);
    chk("R5 no miss on accept", {31'b0, rx_missed}, 32'h0);
    rx_pulse(32'h0000_003C);
    rd(10'h110, d); chk("R6 clean status", d, 32'h0000_003C);
    rx_pulse(32'h77);
    chk("R5 missed pulse", {31'b0, rx_missed}, 32'h1);
    @(negedge clk);
    chk("R5 missed one cycle", {31'b0, rx_missed}, 32'h0);
    rd(10'h108, d); chk("R3 R5 rx idx stays 2", d, 32'h0000_200A);
    rd(10'h120, d); chk("R5 stalled rx no status", d, 32'h0);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(10'h128, 32'h2201);
    chk("R9 rx slot2 ready", {31'b0, rx_ready}, 32'h1);
    chk("R7 irq before clear", {31'b0, irq}, 32'h1);
    wr(10'h200, 32'h0);
    rd(10'h128, d); chk("R8 enable cleared, addr kept", d, 32'h0000_2200);
    rd(10'h108, d); chk("R8 done cleared, idx kept", d, 32'h0000_2008);
    rd(10'h004, d); chk("R8 length kept", d, 32'd60);
    chk("R8 irq low", {31'b0, irq}, 32'h0);
    chk("R8 rx not ready", {31'b0, rx_ready}, 32'h0);
    wr(10'h128, 32'h2201);
    rx_pulse(32'h99);
    chk("R8 disabled no miss", {31'b0, rx_missed}, 32'h0);
    rd(10'h120, d); chk("R8 disabled no status", d, 32'h0);
    rd(10'h108, d); chk("R8 disabled idx stays", d, 32'h0000_2008);
    rd(10'h200, d); chk("R8 enable reg reads 0", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write();
    t_tx();
    t_rx();
    t_clear();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule